// File: doc/BRIEF.md
# Trigger-Synchronized Clock Output Gate

This block produces three outputs aligned to an external trigger: a synchronized clock, its complement, and a one-shot pulse. It runs on a fast clock that is eight times the output reference rate. The reference is formed by counting fast-clock cycles, so the output phase can be moved in steps of one eighth of a period. While the trigger is active, all three outputs are frozen in their idle levels. When the trigger is released, the outputs restart from a fixed phase after a fixed number of fast-clock cycles.

A polarity input chooses which pin level counts as active. A disable input forces the complement and the pulse to their idle levels. A 3-bit shift setting delays the output in eighth-period steps. The shift is applied in stages: the first output edge is never shifted, the second edge carries half of the shift, and the third and later edges carry all of it. The outputs are only meaningful after the trigger has been released twice, and a valid flag reports that condition.

Top module: `trig_clk_gate`

## Requirements
- R1: The internal trigger is `trig_i` XOR `pol_neg_i`. With `pol_neg_i`=0 the trigger is active while the pin is high. With `pol_neg_i`=1 it is active while the pin is low.
- R2: From the second fast-clock edge after the internal trigger becomes active, and for as long as it stays active: `sclk_o`=0, `pulse_o`=0 and `sclk_n_o`=1.
- R3: Count fast-clock edges from the first edge that samples the released trigger, calling that edge 1. `sclk_o` stays low through edge 5 and rises at edge 6. This first edge does not depend on the shift setting.
- R4: While `dis_i`=0, `sclk_n_o` is always the complement of `sclk_o`.
- R5: `pulse_o` rises together with the first rise of `sclk_o` (edge 6). It stays high until the fifth output edge, at edge 22+s, where s is `shift_i`.
- R6: With shift s, the second output edge (the fall) comes at edge 10+floor(s/2). The third edge (a rise) comes at edge 14+s. After that the clock has a period of 8 cycles and is high for 4 of them.
- R7: `dis_i`=1 forces `sclk_n_o`=1 and `pulse_o`=0 and leaves `sclk_o` unchanged.
- R8: `valid_o` is 0 after reset. It becomes 1 at edge 3 after the second trigger release and stays 1 until reset.
- R9: While `rst_ni`=0: `sclk_o`=0, `sclk_n_o`=1, `pulse_o`=0, `valid_o`=0.
- R10: If the trigger is asserted again while the outputs are running, the outputs freeze as in R2. The following release restarts the outputs with the same timing as R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock, eight times the output rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger pin, asynchronous |
| pol_neg_i | input | 1 | Trigger polarity select |
| dis_i | input | 1 | Forces the complement and the pulse idle |
| shift_i | input | 3 | Phase shift in eighth-period steps |
| sclk_o | output | 1 | Synchronized clock |
| sclk_n_o | output | 1 | Complement of the synchronized clock |
| pulse_o | output | 1 | One-shot pulse after each release |
| valid_o | output | 1 | High once two releases have been seen |

## Verification
The internal state is a phase counter, a stall counter and an edge counter.

- **Stall counter:** a wrong value moves the second or third output edge of a run. This shows within about 20 cycles of the release.
- **Edge counter:** a fault changes where the pulse ends or where the shift is applied. The pulse end shows at edge 22+s.
- **Synchronizer or release counter:** a fault shifts every edge of every run by a fixed amount, or moves the cycle where `valid_o` rises on the second release.

Every run is compared cycle by cycle against edge times computed from the shift value, so any of these faults shows within one run.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int unsigned DIV_DEF  = 8;
  localparam int unsigned EDGE_MAX = 5;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/tcg_trig_sync.sv
module tcg_trig_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_neg_i,
  output logic act_o,
  output logic valid_o
);
  logic s1_q, s2_q, s3_q;
  logic [1:0] rel_cnt_q;
  logic rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig_i ^ pol_neg_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rel = s3_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_cnt_q <= '0;
    else if (rel && !rel_cnt_q[1]) rel_cnt_q <= rel_cnt_q + 2'd1;
  end

  assign act_o   = s2_q;
  assign valid_o = rel_cnt_q[1];

  a_r8_valid_needs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(rel));
  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
endmodule

// File: rtl/tcg_phase_gen.sv
module tcg_phase_gen #(
  parameter int unsigned DIV  = tcg_pkg::DIV_DEF,
  parameter int unsigned PH_W = tcg_pkg::clog2_min1(DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            act_i,
  input  logic [PH_W-1:0] shift_i,
  output logic            clk_raw_o,
  output logic            pulse_raw_o
);
  localparam int unsigned HALF = DIV / 2;

  logic [PH_W-1:0] ph_q, stall_q;
  logic [2:0]      edge_q;
  logic [PH_W-1:0] shift_half, shift_rest;
  logic            rise_evt, fall_evt;

  assign shift_half = shift_i >> 1;
  assign shift_rest = shift_i - shift_half;
  assign rise_evt   = (ph_q == PH_W'(HALF - 1));
  assign fall_evt   = (ph_q == PH_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      stall_q <= '0;
      edge_q  <= '0;
    end else if (act_i) begin
      ph_q    <= '0;
      stall_q <= '0;
      edge_q  <= '0;
    end else if (stall_q != '0) begin
      stall_q <= stall_q - 1'b1;
    end else begin
      ph_q <= fall_evt ? '0 : ph_q + 1'b1;
      if ((rise_evt || fall_evt) && edge_q < 3'(tcg_pkg::EDGE_MAX))
        edge_q <= edge_q + 3'd1;
      // half the shift before edge 2, the rest before edge 3
      if (rise_evt && edge_q == 3'd0)      stall_q <= shift_half;
      else if (fall_evt && edge_q == 3'd1) stall_q <= shift_rest;
    end
  end

  assign clk_raw_o   = (ph_q >= PH_W'(HALF)) & ~act_i;
  assign pulse_raw_o = (edge_q != 3'd0) && (edge_q < 3'(tcg_pkg::EDGE_MAX)) && !act_i;

  a_r2_held_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && $past(act_i)) |-> (ph_q == '0 && edge_q == 3'd0 && stall_q == '0));
  a_r6_stall_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q <= PH_W'(HALF));
  a_r6_stall_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_q != '0) |-> (edge_q == 3'd1 || edge_q == 3'd2));
  a_r5_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_raw_o) |-> $rose(clk_raw_o));
endmodule

// File: rtl/tcg_out_stage.sv
module tcg_out_stage (
  input  logic clk_raw_i,
  input  logic pulse_raw_i,
  input  logic dis_i,
  output logic sclk_o,
  output logic sclk_n_o,
  output logic pulse_o
);
  assign sclk_o   = clk_raw_i;
  assign sclk_n_o = dis_i | ~clk_raw_i;
  assign pulse_o  = ~dis_i & pulse_raw_i;
endmodule

// File: rtl/trig_clk_gate.sv
module trig_clk_gate #(
  parameter int unsigned DIV  = tcg_pkg::DIV_DEF,
  parameter int unsigned PH_W = tcg_pkg::clog2_min1(DIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trig_i,
  input  logic            pol_neg_i,
  input  logic            dis_i,
  input  logic [PH_W-1:0] shift_i,
  output logic            sclk_o,
  output logic            sclk_n_o,
  output logic            pulse_o,
  output logic            valid_o
);
  logic act, clk_raw, pulse_raw;

  tcg_trig_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .pol_neg_i (pol_neg_i),
    .act_o     (act),
    .valid_o   (valid_o)
  );

  tcg_phase_gen #(.DIV(DIV), .PH_W(PH_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act),
    .shift_i     (shift_i),
    .clk_raw_o   (clk_raw),
    .pulse_raw_o (pulse_raw)
  );

  tcg_out_stage u_out (
    .clk_raw_i   (clk_raw),
    .pulse_raw_i (pulse_raw),
    .dis_i       (dis_i),
    .sclk_o      (sclk_o),
    .sclk_n_o    (sclk_n_o),
    .pulse_o     (pulse_o)
  );

  a_r2_frozen_ports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> (!sclk_o && !pulse_o && sclk_n_o));
  a_r4_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dis_i |-> (sclk_n_o == !sclk_o));
  a_r7_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |-> (sclk_n_o && !pulse_o));
endmodule

// File: tb/trig_clk_gate_tb.sv
module trig_clk_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, pol = 1'b0, dis = 1'b0;
  logic [2:0] shift = 3'd0;
  logic sclk, sclk_n, pulse, valid;
  int checks = 0, failures = 0, n_rel = 0;
  logic done = 1'b0;
  logic retrig = 1'b0;

  always #5 clk = ~clk;

  trig_clk_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .pol_neg_i(pol), .dis_i(dis),
    .shift_i(shift), .sclk_o(sclk), .sclk_n_o(sclk_n), .pulse_o(pulse), .valid_o(valid)
  );

  function automatic logic exp_clk(int k, int s);
    int e2 = 10 + s / 2;
    int e3 = 14 + s;
    if (k < 6)  return 1'b0;
    if (k < e2) return 1'b1;
    if (k < e3) return 1'b0;
    return ((k - e3) % 8) < 4;
  endfunction

  function automatic logic exp_pulse(int k, int s);
    return (k >= 6) && (k < 22 + s);
  endfunction

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  // assert trigger, hold, then release and follow the run for len cycles
  task automatic run(logic p, int s, logic d, int hold, int len);
    @(negedge clk);
    pol = p; trig = p;            // idle: internal trigger low
    @(negedge clk);
    trig = ~p;                    // active (R1)
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk(p ? "R1 neg-pol frozen sclk" : (retrig ? "R10 frozen sclk" : "R2 frozen sclk"), sclk, 1'b0);
        chk("R2 frozen pulse", pulse, 1'b0);
        chk("R2 frozen sclk_n", sclk_n, 1'b1);
        chk("R8 valid while active", valid, n_rel >= 2);
      end
    end
    shift = 3'(s); dis = d;
    trig = p;                     // release
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      chk(k <= 6 ? (retrig ? "R10 restart" : "R3 first edge") : "R6 shifted edges", sclk, exp_clk(k, s));
      if (d) begin
        chk("R7 sclk_n forced", sclk_n, 1'b1);
        chk("R7 pulse forced", pulse, 1'b0);
      end else begin
        chk("R4 complement", sclk_n, ~exp_clk(k, s));
        chk("R5 pulse", pulse, exp_pulse(k, s));
      end
      chk("R8 valid", valid, (n_rel >= 2) || (n_rel == 1 && k >= 3));
    end
    n_rel++;
    retrig = (len < 22 + s);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R9 reset sclk", sclk, 1'b0);
    chk("R9 reset sclk_n", sclk_n, 1'b1);
    chk("R9 reset pulse", pulse, 1'b0);
    chk("R9 reset valid", valid, 1'b0);
    #22 rst_n = 1'b1;
    run(1'b0, 7, 1'b0, 4, 40);
    run(1'b1, 0, 1'b0, 5, 40);
    run(1'b0, 1, 1'b0, 3, 12);    // cut short: next run is a retrigger
    run(1'b0, 5, 1'b1, 6, 36);
    run(1'b1, 6, 1'b0, 3, 10);
    run(1'b1, 3, 1'b0, 4, 40);
    for (int i = 0; i < 30; i++)
      run(1'($urandom % 2), int'($urandom % 8), 1'($urandom % 2),
          3 + int'($urandom % 8), 8 + int'($urandom % 33));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule